// File: doc/BRIEF.md
# Serial ADC Command and Sampling Sequencer

This block is the digital control front end of an eight-input serial converter. It runs on a fast system clock and oversamples the host's serial clock, data and chip-select pins. In each frame it shifts in a four-bit command, one bit per active serial clock edge. The command selects an external channel, enters power-down, sets the conversion rate, picks one of three internal test voltages, or does nothing.

For conversion commands it drives the sample and hold strobes of the analog front end from a count of serial clock edges. It also steers the input multiplexer with a dead gap, so two inputs are never enabled together.

It owns the result word. A channel conversion returns the code handed in by the external converter. A test selection returns a fixed code. Every other command leaves no valid result.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, power_down_o=0, fast_rate_o=1, mux_en_o=11'h001 (channel 0), result_valid_o=0, result_o=0, sample_o=0, hold_o=0.
- R2: The active serial edge is rising when clk_norm_i XOR dsp_mode_i is 1, and falling otherwise. The four command bits are taken MSB first on the first four active edges after cs_ni falls.
- R3: A command of 0h to 7h selects external channel n and drives mux_en_o bit n, with bits 0 to 7 being the external inputs.
- R4: Command 8h sets power_down_o. The next completed command of any other code clears it.
- R5: Command 9h sets fast_rate_o to 1 and command Ah sets it to 0. The rate holds until the other code completes.
- R6: Commands Bh, Ch and Dh enable mux_en_o bit 8, 9 and 10. At the hold strobe they make result_o 200h, 000h and 3FFh respectively, with result_valid_o=1.
- R7: Commands Eh and Fh change neither mux_en_o nor the rate. They leave result_valid_o at 0.
- R8: For a conversion command (0h to 7h, Bh to Dh) with cstart_i high at the 4th active edge, sample_o rises on that edge and falls on the 10th active edge. hold_o pulses for one cycle on the 10th active edge.
- R9: mux_en_o never has more than one bit set. When the selection changes, mux_en_o is all zero for exactly BBM_CYC cycles between the old bit and the new bit.
- R10: A frame ended by cs_ni rising before the 4th active edge changes no state. If it ends during the sample window, sample_o drops and no hold_o pulse follows.
- R11: After the hold strobe of a channel command, the next conv_done_i pulse loads conv_code_i into result_o and sets result_valid_o. A conv_done_i pulse at any other time is ignored. Each completed command clears result_valid_o and result_o.
- R12: If cstart_i is low at the 4th active edge, the frame makes no sample_o or hold_o strobe and yields no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| io_clk_i | input | 1 | Serial clock from host |
| data_i | input | 1 | Serial command data |
| clk_norm_i | input | 1 | 1 = normal serial clock, 0 = inverted |
| dsp_mode_i | input | 1 | 1 = DSP-style framing, 0 = microcontroller-style |
| cstart_i | input | 1 | High selects normal (fixed-window) sampling |
| conv_done_i | input | 1 | Converter finished pulse |
| conv_code_i | input | RES_W | Converter output code |
| mux_en_o | output | 11 | One-hot input enable, bits 0-7 external, 8 mid, 9 low, 10 high |
| sample_o | output | 1 | Sampling window |
| hold_o | output | 1 | One-cycle hold strobe |
| power_down_o | output | 1 | Software power-down state |
| fast_rate_o | output | 1 | 1 = fast rate, 0 = slow rate |
| result_o | output | RES_W | Returned result |
| result_valid_o | output | 1 | result_o holds a valid result |

## Verification
A misaligned shift register or a wrong edge choice shows up as the wrong mux_en_o bit a few system cycles after the 4th active edge. A miscounted edge counter moves the sample_o window by a whole serial pulse, and it is caught at the pulse where it should have opened or closed. A sticky mode register that holds a stale value shows on power_down_o or fast_rate_o at the next completed command. A pending-result flag that is wrong either turns a stray conv_done_i into a valid result or loses the real one, and result_valid_o shows this at the end of the frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned EXT_CH  = 8;
  localparam int unsigned TEST_CH = 3;
  localparam int unsigned MUX_N   = EXT_CH + TEST_CH;
  localparam int unsigned SEL_W   = $clog2(MUX_N);

  typedef enum logic [2:0] {
    K_CHAN, K_PDOWN, K_FAST, K_SLOW, K_TEST, K_RSVD
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic [SEL_W-1:0] mux_idx;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_dec_t d;
    d.kind    = K_RSVD;
    d.mux_idx = '0;
    if (c < 4'h8) begin
      d.kind    = K_CHAN;
      d.mux_idx = SEL_W'(c);
    end else begin
      case (c)
        4'h8: d.kind = K_PDOWN;
        4'h9: d.kind = K_FAST;
        4'hA: d.kind = K_SLOW;
        4'hB, 4'hC, 4'hD: begin
          d.kind    = K_TEST;
          d.mux_idx = SEL_W'(c - 4'h3);  // B->8, C->9, D->10
        end
        default: d.kind = K_RSVD;
      endcase
    end
    return d;
  endfunction

  function automatic logic is_conv(input cmd_kind_e k);
    return (k == K_CHAN) || (k == K_TEST);
  endfunction
endpackage

// File: rtl/io_sync_edge.sv
module io_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_clk_i,
  input  logic data_i,
  input  logic cs_ni,
  input  logic cap_rise_i,
  output logic cap_o,
  output logic bit_o,
  output logic cs_act_o,
  output logic frame_start_o
);
  logic [STAGES-1:0] clk_s, dat_s, csn_s;
  logic clk_d, csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_s <= '0;
      dat_s <= '0;
      csn_s <= '1;
      clk_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      clk_s <= {clk_s[STAGES-2:0], io_clk_i};
      dat_s <= {dat_s[STAGES-2:0], data_i};
      csn_s <= {csn_s[STAGES-2:0], cs_ni};
      clk_d <= clk_s[STAGES-1];
      csn_d <= csn_s[STAGES-1];
    end
  end

  logic rise, fall;
  assign rise          = clk_s[STAGES-1] & ~clk_d;
  assign fall          = ~clk_s[STAGES-1] & clk_d;
  assign cs_act_o      = ~csn_s[STAGES-1];
  assign frame_start_o = ~csn_s[STAGES-1] & csn_d;
  assign cap_o         = cs_act_o & (cap_rise_i ? rise : fall);
  assign bit_o         = dat_s[STAGES-1];
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_EDGE = 4,
  parameter int unsigned HOLD_EDGE   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             cs_act_i,
  input  logic             cap_i,
  input  logic             bit_i,
  input  logic             cstart_i,
  output logic             commit_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             sample_o,
  output logic             hold_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_EDGE + 1);

  logic [CNT_W-1:0] edge_cnt, nxt_cnt;
  logic [CMD_W-2:0] shreg;
  logic [CMD_W-1:0] cmd_now;

  assign nxt_cnt = edge_cnt + 1'b1;
  assign cmd_now = (nxt_cnt == CNT_W'(CMD_W)) ? {shreg, bit_i} : cmd_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      shreg    <= '0;
      cmd_o    <= '0;
      commit_o <= 1'b0;
      sample_o <= 1'b0;
      hold_o   <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      hold_o   <= 1'b0;
      if (frame_start_i) begin
        edge_cnt <= '0;
        shreg    <= '0;
        sample_o <= 1'b0;
      end else if (!cs_act_i) begin
        sample_o <= 1'b0;  // aborted frame: no hold
      end else if (cap_i && edge_cnt != CNT_W'(HOLD_EDGE)) begin
        edge_cnt <= nxt_cnt;
        if (edge_cnt < CNT_W'(CMD_W - 1)) shreg <= {shreg[CMD_W-3:0], bit_i};
        if (nxt_cnt == CNT_W'(CMD_W)) begin
          commit_o <= 1'b1;
          cmd_o    <= cmd_now;
        end
        if (nxt_cnt == CNT_W'(SAMPLE_EDGE) && cstart_i && is_conv(decode_cmd(cmd_now).kind))
          sample_o <= 1'b1;
        if (nxt_cnt == CNT_W'(HOLD_EDGE) && sample_o) begin
          sample_o <= 1'b0;
          hold_o   <= 1'b1;
        end
      end
    end
  end

  // R8: hold only closes an open window
  a_r8_hold_ends_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> ($past(sample_o) && !sample_o));
  // R10: window never survives the frame
  a_r10_sample_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(cs_act_i));
endmodule

// File: rtl/mux_bbm.sv
module mux_bbm #(
  parameter int unsigned MUX_N = 11,
  parameter int unsigned GAP   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [$clog2(MUX_N)-1:0] sel_i,
  output logic [MUX_N-1:0]         en_o
);
  localparam int unsigned SEL_W = $clog2(MUX_N);
  localparam int unsigned GW    = $clog2(GAP + 1);

  logic [SEL_W-1:0] cur_sel;
  logic [GW-1:0]    gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_sel <= '0;
      gap_cnt <= '0;
    end else if (load_i && sel_i != cur_sel) begin
      cur_sel <= sel_i;
      gap_cnt <= GW'(GAP);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < MUX_N; i++) begin : g_en
    assign en_o[i] = (gap_cnt == '0) && (cur_sel == SEL_W'(i));
  end

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_o));
  a_r9_no_direct_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != '0 && $past(en_o) != '0) |-> en_o == $past(en_o));
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BBM_CYC     = 2,
  parameter int unsigned SAMPLE_EDGE = 4,
  parameter int unsigned HOLD_EDGE   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             io_clk_i,
  input  logic             data_i,
  input  logic             clk_norm_i,
  input  logic             dsp_mode_i,
  input  logic             cstart_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_code_i,
  output logic [10:0]      mux_en_o,
  output logic             sample_o,
  output logic             hold_o,
  output logic             power_down_o,
  output logic             fast_rate_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o
);
  logic cap, bit_v, cs_act, frame_start, commit;
  logic [CMD_W-1:0] cmd;
  cmd_dec_t dec;

  io_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .io_clk_i, .data_i, .cs_ni,
    .cap_rise_i   (clk_norm_i ^ dsp_mode_i),
    .cap_o        (cap),
    .bit_o        (bit_v),
    .cs_act_o     (cs_act),
    .frame_start_o(frame_start)
  );

  frame_seq #(.SAMPLE_EDGE(SAMPLE_EDGE), .HOLD_EDGE(HOLD_EDGE)) u_frame (
    .clk_i, .rst_ni,
    .frame_start_i(frame_start),
    .cs_act_i     (cs_act),
    .cap_i        (cap),
    .bit_i        (bit_v),
    .cstart_i,
    .commit_o     (commit),
    .cmd_o        (cmd),
    .sample_o,
    .hold_o
  );

  assign dec = decode_cmd(cmd);

  mux_bbm #(.MUX_N(MUX_N), .GAP(BBM_CYC)) u_mux (
    .clk_i, .rst_ni,
    .load_i(commit && is_conv(dec.kind)),
    .sel_i (dec.mux_idx),
    .en_o  (mux_en_o)
  );

  logic [RES_W-1:0] test_code;
  always_comb begin
    case (cmd)
      4'hB:    test_code = {1'b1, {(RES_W-1){1'b0}}};
      4'hC:    test_code = '0;
      default: test_code = '1;
    endcase
  end

  logic pend;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      power_down_o   <= 1'b0;
      fast_rate_o    <= 1'b1;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      pend           <= 1'b0;
    end else if (commit) begin
      power_down_o   <= (dec.kind == K_PDOWN);
      if (dec.kind == K_FAST) fast_rate_o <= 1'b1;
      if (dec.kind == K_SLOW) fast_rate_o <= 1'b0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      pend           <= 1'b0;
    end else if (hold_o) begin
      if (dec.kind == K_TEST) begin
        result_o       <= test_code;
        result_valid_o <= 1'b1;
      end else begin
        pend <= 1'b1;
      end
    end else if (pend && conv_done_i) begin
      result_o       <= conv_code_i;
      result_valid_o <= 1'b1;
      pend           <= 1'b0;
    end
  end

  a_r4_pd_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(power_down_o) |-> $past(commit));
  a_r5_rate_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fast_rate_o) |-> $past(commit));
  a_r11_valid_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_valid_o) |-> $past(hold_o || conv_done_i));
  a_r12_no_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> $past(cstart_i));
endmodule

// File: tb/test_adc_cmd_seq.sv
module test_adc_cmd_seq;
  localparam int Q   = 6;
  localparam int BBM = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, io_clk = 1'b0, data = 1'b0, clk_norm = 1'b1, dsp = 1'b0;
  logic cstart = 1'b1, conv_done = 1'b0;
  logic [9:0]  conv_code = '0;
  logic [10:0] mux_en;
  logic sample, hold, pd, fast, valid;
  logic [9:0] result;

  always #2.5 clk = ~clk;

  adc_cmd_seq #(.BBM_CYC(BBM)) i_adc_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .io_clk_i(io_clk), .data_i(data),
    .clk_norm_i(clk_norm), .dsp_mode_i(dsp), .cstart_i(cstart),
    .conv_done_i(conv_done), .conv_code_i(conv_code),
    .mux_en_o(mux_en), .sample_o(sample), .hold_o(hold), .power_down_o(pd),
    .fast_rate_o(fast), .result_o(result), .result_valid_o(valid)
  );

  typedef struct {
    string       req;
    logic        pd;
    logic        fast;
    logic [10:0] mux;
    logic        valid;
    logic [9:0]  res;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0;
  int hold_cnt = 0;
  logic [10:0] last_nz = 11'h001;
  int zero_run = 0, min_gap = 1000, max_gap = -1, overlap = 0;

  logic       m_pd = 0, m_fast = 1, m_valid = 0;
  logic [3:0] m_sel = 0;
  logic [9:0] m_res = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (hold) hold_cnt++;
      if ($countones(mux_en) > 1) overlap++;
      if (mux_en == '0) zero_run++;
      else begin
        if (mux_en != last_nz) begin
          if (zero_run < min_gap) min_gap = zero_run;
          if (zero_run > max_gap) max_gap = zero_run;
        end
        last_nz  = mux_en;
        zero_run = 0;
      end
    end
  end

  // monitor: compares queued expectations against ports
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk);
      begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.req, " R4 power_down"}, 32'(pd), 32'(e.pd));
        chk({e.req, " R5 fast_rate"}, 32'(fast), 32'(e.fast));
        chk({e.req, " R3 mux_en"}, 32'(mux_en), 32'(e.mux));
        chk({e.req, " R11 result_valid"}, 32'(valid), 32'(e.valid));
        chk({e.req, " R6 result"}, 32'(result), 32'(e.res));
      end
    end
  end

  task automatic pulse(input logic b, input logic rise);
    data = rise ? b : ~b;
    wait_n(Q); io_clk = 1'b1;
    wait_n(Q); data = rise ? ~b : b;  // wrong edge would see the inverse
    wait_n(Q); io_clk = 1'b0;
    wait_n(2 * Q);
  endtask

  task automatic run_frame(input string req, input logic [3:0] c, input int nedges,
                           input logic cs_v, input logic norm_v, input logic dsp_v,
                           input logic [9:0] code);
    logic rise, conv, do_samp, do_hold, pending;
    int h0;
    rise    = norm_v ^ dsp_v;
    conv    = (c < 4'h8) || (c >= 4'hB && c <= 4'hD);
    do_samp = conv && cs_v && nedges >= 4;
    do_hold = do_samp && nedges >= 10;
    pending = 1'b0;
    clk_norm = norm_v; dsp = dsp_v; cstart = cs_v;
    h0 = hold_cnt;
    wait_n(2 * Q);
    cs_n = 1'b0;
    wait_n(2 * Q);
    for (int k = 1; k <= nedges; k++) begin
      pulse((k <= 4) ? c[4 - k] : k[0], rise);
      if (k == 3 || k == 10) chk({req, " R8 sample off"}, 32'(sample), 0);
      if (k == 4 || k == 9)  chk({req, " R8/R12 sample window"}, 32'(sample), 32'(do_samp));
    end
    cs_n = 1'b1;
    wait_n(2 * Q);
    chk({req, " R10 sample after frame"}, 32'(sample), 0);
    chk({req, " R8/R10/R12 hold count"}, 32'(hold_cnt - h0), 32'(do_hold));
    if (nedges >= 4) begin
      m_pd = (c == 4'h8);
      if (c == 4'h9) m_fast = 1'b1;
      if (c == 4'hA) m_fast = 1'b0;
      if (conv) m_sel = (c < 4'h8) ? c : c - 4'h3;
      m_valid = 1'b0; m_res = '0;
      if (do_hold) begin
        if (c >= 4'hB) begin
          m_valid = 1'b1;
          m_res = (c == 4'hB) ? 10'h200 : (c == 4'hC) ? 10'h000 : 10'h3FF;
        end else pending = 1'b1;
      end
    end
    // every frame ends with a converter pulse; accepted only when pending
    conv_code = code; conv_done = 1'b1;
    wait_n(1);
    conv_done = 1'b0; conv_code = '0;
    if (pending) begin m_valid = 1'b1; m_res = code; end
    wait_n(BBM + 4);
    exp_q.push_back('{req, m_pd, m_fast, 11'(1) << m_sel, m_valid, m_res});
    wait (exp_q.size() == 0);
    wait_n(2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 power_down", 32'(pd), 0);
    chk("R1 fast_rate", 32'(fast), 1);
    chk("R1 mux_en", 32'(mux_en), 32'h001);
    chk("R1 result_valid", 32'(valid), 0);
    chk("R1 result", 32'(result), 0);
    chk("R1 sample", 32'(sample), 0);
    chk("R1 hold", 32'(hold), 0);

    run_frame("R3 R2 ch3 rise",      4'h3, 10, 1, 1, 0, 10'h155);
    run_frame("R3 R2 ch5 fall",      4'h5, 10, 1, 0, 0, 10'h2AA);
    run_frame("R3 R2 ch6 dsp fall",  4'h6, 10, 1, 1, 1, 10'h0F3);
    run_frame("R3 R2 ch1 dsp rise",  4'h1, 12, 1, 0, 1, 10'h301);
    run_frame("R3 ch7",              4'h7, 10, 1, 1, 0, 10'h07F);
    run_frame("R3 ch0",              4'h0, 10, 1, 1, 0, 10'h3FE);
    run_frame("R4 pdown",            4'h8, 4,  1, 1, 0, 10'h111);
    run_frame("R5 R4 slow clears pd",4'hA, 10, 1, 1, 0, 10'h111);
    run_frame("R4 pdown again",      4'h8, 6,  1, 0, 1, 10'h111);
    run_frame("R5 R4 fast",          4'h9, 4,  1, 1, 0, 10'h111);
    run_frame("R6 mid",              4'hB, 10, 1, 1, 0, 10'h155);
    run_frame("R6 low",              4'hC, 10, 1, 0, 0, 10'h155);
    run_frame("R6 high",             4'hD, 10, 1, 1, 1, 10'h155);
    run_frame("R7 rsvd E",           4'hE, 10, 1, 1, 0, 10'h155);
    run_frame("R5 slow",             4'hA, 4,  1, 1, 0, 10'h155);
    run_frame("R7 rsvd F",           4'hF, 10, 1, 0, 1, 10'h155);
    run_frame("R10 abort early",     4'h8, 3,  1, 1, 0, 10'h155);
    run_frame("R10 abort in window", 4'h2, 7,  1, 1, 0, 10'h155);
    run_frame("R12 cstart low",      4'h4, 10, 0, 1, 0, 10'h155);
    run_frame("R11 same channel",    4'h4, 10, 1, 0, 0, 10'h2C4);

    chk("R9 no overlap", 32'(overlap), 0);
    chk("R9 min gap", 32'(min_gap), BBM);
    chk("R9 max gap", 32'(max_gap), BBM);
    finish_run();
  end
endmodule